// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt events from seven sources and turns them into one vectored interrupt for a small CPU core. The sources are a wakeup pin, an external interrupt pin, three timer overflows (A, B, C), a serial interface and an A/D converter. Each source has a request flag that is set by a one-cycle event pulse from its peripheral, and a mask bit. One global enable bit gates the whole controller. All of these bits sit in a small register window, and the CPU sets or clears them one bit at a time.

When the CPU marks an instruction boundary, the controller may accept an interrupt. This needs the global enable bit to be 1 and at least one unmasked request flag to be set. On acceptance it runs a fixed three-cycle sequence. The first cycle lets the current instruction finish. The second cycle drops the global enable and starts the context-save strobe. The third cycle keeps the save strobe and emits the vector address with a jump strobe. The serial interface and the A/D converter share one vector, so the handler must look at the flags to find the cause. Request flags stay set after acceptance, and the handler clears them.

Top module: `irqc_top`

## Requirements
- R1: After reset the global enable and all seven request flags read 0 and all seven mask bits read 1. `irq_req`, `seq_busy`, `ctx_save` and `vec_jump` are all 0.
- R2: A source is pending only when its flag is 1 and its mask is 0. `irq_req` is 1 while at least one source is pending, and it does not depend on the global enable.
- R3: An acceptance starts only in a cycle where `instr_boundary`, the global enable and at least one pending source are all 1. If the enable is 0 or no boundary is signalled, `seq_busy` stays 0.
- R4: A 1 on `evt_i[i]` sets flag i at the next clock edge. A register write of 0 to a flag clears it. A write of 1 to a flag leaves it unchanged.
- R5: When an event pulse and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: Among pending sources, the lowest `evt_i` index wins. The index order is 0 wakeup, 1 external, 2 timer A, 3 timer B, 4 timer C, 5 serial, 6 A/D. The vectors are 0x002, 0x004, 0x006, 0x008 and 0x00A for indices 0 to 4. Indices 5 and 6 share 0x00C.
- R7: Let N be the accepting cycle. In cycle N+1, `seq_busy`=1 and the strobes are 0. In cycle N+2, `ctx_save`=1 and the global enable reads 0. In cycle N+3, `ctx_save`=1 and `vec_jump`=1, with `vec_addr` holding the vector. In cycle N+4, `seq_busy`=0. At all other times `vec_addr` is 0.
- R8: Acceptance never clears a request flag.
- R9: No acceptance starts while a sequence is running. After a sequence, no further acceptance occurs until software sets the global enable again.
- R10: The register layout maps each address to bits 3..0 as follows. Unused bits and other addresses read 0.
  - 0x000: {0, wakeup mask, wakeup flag, global enable}
  - 0x001: {timer A mask, timer A flag, external mask, external flag}
  - 0x002: {timer C mask, timer C flag, timer B mask, timer B flag}
  - 0x003: {0, 0, serial mask, serial flag}
  - 0x023: {0, 0, A/D mask, A/D flag}

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 7 | One-cycle event pulses, index order as in R6 |
| instr_boundary | input | 1 | CPU is at an instruction boundary |
| reg_addr | input | 10 | Register window address (read and write) |
| reg_bit | input | 2 | Bit position for a bit write |
| reg_bit_we | input | 1 | Bit write strobe |
| reg_bit_val | input | 1 | Value written to the selected bit |
| reg_rdata | output | 4 | Contents of the addressed word |
| irq_req | output | 1 | At least one source pending |
| seq_busy | output | 1 | Acceptance sequence in progress |
| ctx_save | output | 1 | Save carry, status and program counter |
| vec_jump | output | 1 | Jump to `vec_addr` |
| vec_addr | output | 12 | Vector address, valid with `vec_jump` |

## Verification
The bench observes the controller only through its ports, so any error in its internal state has to show up there.
- A corrupted flag or mask shows up on `reg_rdata` in the same cycle, and on `irq_req` one edge after the event or write that caused it.
- A wrong priority choice or a vector latched at the wrong time appears as a bad `vec_addr` exactly three cycles after the boundary.
- A sequence state that skips or repeats a step shows up as a missing or misplaced `ctx_save` or `vec_jump` pulse within four cycles.
- A global enable that is not cleared shows up as a second acceptance on the next boundary.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FINISH = 2'd1,
    SEQ_SAVE   = 2'd2,
    SEQ_JUMP   = 2'd3
  } seq_state_t;

  localparam int WINDOW_WORDS = 5;

  // Which window word holds the flag/mask pair of a source.
  function automatic int slot_word(input int src);
    if (src == 0)      return 0;
    else if (src <= 4) return 1 + (src - 1) / 2;
    else               return src - 2;
  endfunction

  // Bit of the flag inside its word; the mask sits one bit above.
  function automatic int slot_bit(input int src);
    if (src == 0)      return 1;
    else if (src <= 4) return 2 * ((src - 1) % 2);
    else               return 0;
  endfunction

  // Address to window word index, -1 when unmapped.
  function automatic int word_index(input int addr);
    if (addr >= 0 && addr <= 3) return addr;
    else if (addr == 'h23)      return 4;
    else                        return -1;
  endfunction

  // Vector for a winning source index; sources from shared_from up share one.
  function automatic int vector_of(input int idx, input int base,
                                   input int step, input int shared_from);
    if (idx >= shared_from) return base + step * shared_from;
    else                    return base + step * idx;
  endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC   = 7,
  parameter int ADDR_W = 10,
  parameter int WORD_W = 4,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BIT_W-1:0]  wr_bit,
  input  logic              wr_val,
  input  logic              gie_clr,
  output logic [WORD_W-1:0] rd_data,
  output logic [NSRC-1:0]   flag_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   sw_clr_o,
  output logic              gie_o
);

  int  word_sel;
  logic gie_hit;

  assign word_sel = word_index(int'(addr));
  assign gie_hit  = wr_en && (word_sel == 0) && (int'(wr_bit) == 0);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int SW = slot_word(i);
    localparam int SB = slot_bit(i);
    logic f_q, m_q, hit_f, hit_m;

    assign hit_f       = wr_en && (word_sel == SW) && (int'(wr_bit) == SB);
    assign hit_m       = wr_en && (word_sel == SW) && (int'(wr_bit) == SB + 1);
    assign sw_clr_o[i] = hit_f && !wr_val;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        m_q <= 1'b1;
      end else begin
        if (evt_i[i])         f_q <= 1'b1;
        else if (sw_clr_o[i]) f_q <= 1'b0;
        if (hit_m)            m_q <= wr_val;
      end
    end

    assign flag_o[i] = f_q;
    assign mask_o[i] = m_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie_o <= 1'b0;
    else if (gie_clr) gie_o <= 1'b0;
    else if (gie_hit) gie_o <= wr_val;
  end

  always_comb begin
    rd_data = '0;
    if (word_sel == 0) rd_data[0] = gie_o;
    for (int i = 0; i < NSRC; i++) begin
      if (word_sel == slot_word(i)) begin
        rd_data[slot_bit(i)]     = flag_o[i];
        rd_data[slot_bit(i) + 1] = mask_o[i];
      end
    end
  end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
#(
  parameter int NSRC        = 7,
  parameter int VEC_W       = 12,
  parameter int VEC_BASE    = 2,
  parameter int VEC_STEP    = 2,
  parameter int SHARED_FROM = 5
) (
  input  logic [NSRC-1:0]  pending,
  output logic             any_o,
  output logic [VEC_W-1:0] vec_o
);

  int win;

  always_comb begin
    win = 0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending[i]) win = i;
    end
  end

  assign any_o = |pending;
  assign vec_o = VEC_W'(vector_of(win, VEC_BASE, VEC_STEP, SHARED_FROM));

endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
  import irqc_pkg::*;
#(
  parameter int VEC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             gie,
  input  logic             any_pend,
  input  logic [VEC_W-1:0] vec_in,
  output logic             accept_o,
  output logic             busy_o,
  output logic             gie_clr_o,
  output logic             save_o,
  output logic             jump_o,
  output logic [VEC_W-1:0] vec_o
);

  seq_state_t state_q;
  logic [VEC_W-1:0] vec_q;

  assign accept_o = (state_q == SEQ_IDLE) && boundary && gie && any_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      vec_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE:   if (accept_o) begin
                      state_q <= SEQ_FINISH;
                      vec_q   <= vec_in;
                    end
        SEQ_FINISH: state_q <= SEQ_SAVE;
        SEQ_SAVE:   state_q <= SEQ_JUMP;
        SEQ_JUMP:   state_q <= SEQ_IDLE;
        default:    state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != SEQ_IDLE);
  assign gie_clr_o = (state_q == SEQ_FINISH);
  assign save_o    = (state_q == SEQ_SAVE) || (state_q == SEQ_JUMP);
  assign jump_o    = (state_q == SEQ_JUMP);
  assign vec_o     = jump_o ? vec_q : '0;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC        = 7,
  parameter int ADDR_W      = 10,
  parameter int WORD_W      = 4,
  parameter int VEC_W       = 12,
  parameter int VEC_BASE    = 2,
  parameter int VEC_STEP    = 2,
  parameter int SHARED_FROM = 5,
  localparam int BIT_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              instr_boundary,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BIT_W-1:0]  reg_bit,
  input  logic              reg_bit_we,
  input  logic              reg_bit_val,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic              seq_busy,
  output logic              ctx_save,
  output logic              vec_jump,
  output logic [VEC_W-1:0]  vec_addr
);

  logic [NSRC-1:0]  flag_w, mask_w, sw_clr_w, pend_w;
  logic             gie_w, gie_clr_w, any_w, accept_w;
  logic [VEC_W-1:0] win_vec_w;

  irqc_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .wr_en(reg_bit_we), .addr(reg_addr), .wr_bit(reg_bit), .wr_val(reg_bit_val),
    .gie_clr(gie_clr_w), .rd_data(reg_rdata),
    .flag_o(flag_w), .mask_o(mask_w), .sw_clr_o(sw_clr_w), .gie_o(gie_w)
  );

  assign pend_w  = flag_w & ~mask_w;
  assign irq_req = any_w;

  irqc_prio #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
              .VEC_STEP(VEC_STEP), .SHARED_FROM(SHARED_FROM)) u_prio (
    .pending(pend_w), .any_o(any_w), .vec_o(win_vec_w)
  );

  irqc_seq #(.VEC_W(VEC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .boundary(instr_boundary), .gie(gie_w),
    .any_pend(any_w), .vec_in(win_vec_w), .accept_o(accept_w),
    .busy_o(seq_busy), .gie_clr_o(gie_clr_w), .save_o(ctx_save),
    .jump_o(vec_jump), .vec_o(vec_addr)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NSRC  = 7,
  parameter int VEC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  evt_i,
  input logic [NSRC-1:0]  flag,
  input logic [NSRC-1:0]  sw_clr,
  input logic [NSRC-1:0]  pending,
  input logic             gie,
  input logic             boundary,
  input logic             accept_go,
  input logic             seq_busy,
  input logic             ctx_save,
  input logic             vec_jump,
  input logic [VEC_W-1:0] vec_addr
);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> flag[i]);
    p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[i] && !evt_i[i]) |=> !flag[i]);
    p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[i] && sw_clr[i]) |=> flag[i]);
    p_flag_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !sw_clr[i]) |=> flag[i]);
  end

  p_accept_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_go |-> (gie && boundary && |pending));
  p_save_then_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_save && !vec_jump) |=> (ctx_save && vec_jump));
  p_gie_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_save && !vec_jump) |-> !gie);
  p_jump_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_jump |=> !seq_busy);
  p_no_reentry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !accept_go);
  p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_jump |-> (vec_addr[0] == 1'b0 && vec_addr >= VEC_W'(2) && vec_addr <= VEC_W'(12)));

endmodule

bind irqc_top irqc_checker #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .flag(flag_w), .sw_clr(sw_clr_w),
  .pending(pend_w), .gie(gie_w), .boundary(instr_boundary), .accept_go(accept_w),
  .seq_busy(seq_busy), .ctx_save(ctx_save), .vec_jump(vec_jump), .vec_addr(vec_addr)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_i = '0;
  logic        instr_boundary = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [1:0]  reg_bit = '0;
  logic        reg_bit_we = 1'b0;
  logic        reg_bit_val = 1'b0;
  logic [3:0]  reg_rdata;
  logic        irq_req, seq_busy, ctx_save, vec_jump;
  logic [11:0] vec_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irqc_top u_irqc_top (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .instr_boundary(instr_boundary),
    .reg_addr(reg_addr), .reg_bit(reg_bit), .reg_bit_we(reg_bit_we),
    .reg_bit_val(reg_bit_val), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .seq_busy(seq_busy), .ctx_save(ctx_save), .vec_jump(vec_jump), .vec_addr(vec_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Flag location per source as the layout table in R10 gives it; mask is one bit up.
  function automatic int loc_addr(input int s);
    case (s)
      0: return 'h000; 1: return 'h001; 2: return 'h001; 3: return 'h002;
      4: return 'h002; 5: return 'h003; default: return 'h023;
    endcase
  endfunction
  function automatic int loc_bit(input int s);
    case (s)
      0: return 1; 2: return 2; 4: return 2; default: return 0;
    endcase
  endfunction
  function automatic int exp_vec(input int s);
    case (s)
      0: return 'h002; 1: return 'h004; 2: return 'h006; 3: return 'h008;
      4: return 'h00A; default: return 'h00C;
    endcase
  endfunction

  task automatic wr(input int a, input int b, input bit v);
    @(negedge clk);
    reg_addr = 10'(a); reg_bit = 2'(b); reg_bit_val = v; reg_bit_we = 1'b1;
    @(negedge clk);
    reg_bit_we = 1'b0;
  endtask

  task automatic rd_bit(input int a, input int b, output bit v);
    reg_addr = 10'(a);
    #1;
    v = reg_rdata[b];
  endtask

  task automatic pulse(input int s);
    @(negedge clk);
    evt_i[s] = 1'b1;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic read_flag(input int s, output bit v);
    rd_bit(loc_addr(s), loc_bit(s), v);
  endtask

  task automatic t_reset;
    int exp_w [5] = '{4'b0100, 4'b1010, 4'b1010, 4'b0010, 4'b0010};
    int addrs [5] = '{'h000, 'h001, 'h002, 'h003, 'h023};
    for (int k = 0; k < 5; k++) begin
      reg_addr = 10'(addrs[k]); #1;
      check(reg_rdata == 4'(exp_w[k]), "R1 reset word", reg_rdata, exp_w[k]);
    end
    reg_addr = 10'h010; #1;
    check(reg_rdata == 4'h0, "R10 unmapped address", reg_rdata, 0);
    check({irq_req, seq_busy, ctx_save, vec_jump} == 4'b0, "R1 outputs idle",
          {irq_req, seq_busy, ctx_save, vec_jump}, 0);
  endtask

  task automatic t_flag_writes;
    bit v;
    wr(loc_addr(3), loc_bit(3), 1'b1);
    read_flag(3, v);
    check(v == 1'b0, "R4 write 1 ignored", v, 0);
    pulse(3);
    read_flag(3, v);
    check(v == 1'b1, "R4 event sets flag", v, 1);
    wr(loc_addr(3), loc_bit(3), 1'b1);
    read_flag(3, v);
    check(v == 1'b1, "R4 write 1 keeps set flag", v, 1);
    wr(loc_addr(3), loc_bit(3), 1'b0);
    read_flag(3, v);
    check(v == 1'b0, "R4 write 0 clears", v, 0);
  endtask

  task automatic t_collision;
    bit v;
    @(negedge clk);
    evt_i[4] = 1'b1;
    reg_addr = 10'(loc_addr(4)); reg_bit = 2'(loc_bit(4)); reg_bit_val = 1'b0; reg_bit_we = 1'b1;
    @(negedge clk);
    evt_i = '0; reg_bit_we = 1'b0;
    read_flag(4, v);
    check(v == 1'b1, "R5 event beats clear", v, 1);
    wr(loc_addr(4), loc_bit(4), 1'b0);
  endtask

  task automatic t_pending;
    bit v;
    pulse(2);
    check(irq_req == 1'b0, "R2 masked flag not pending", irq_req, 0);
    wr(loc_addr(2), loc_bit(2) + 1, 1'b0);
    check(irq_req == 1'b1, "R2 unmasked flag pending", irq_req, 1);
    rd_bit(loc_addr(2), loc_bit(2) + 1, v);
    check(v == 1'b0, "R10 mask reads back", v, 0);
    // Enable still 0: boundaries must not start a sequence.
    @(negedge clk); instr_boundary = 1'b1;
    @(negedge clk); @(negedge clk);
    check(seq_busy == 1'b0, "R3 no accept without enable", seq_busy, 0);
    instr_boundary = 1'b0;
    wr('h000, 0, 1'b1);
    repeat (3) @(negedge clk);
    check(seq_busy == 1'b0, "R3 no accept without boundary", seq_busy, 0);
    wr('h000, 0, 1'b0);
    wr(loc_addr(2), loc_bit(2), 1'b0);
    wr(loc_addr(2), loc_bit(2) + 1, 1'b1);
  endtask

  // Runs one acceptance with the given set of sources armed; checks the R7 timeline.
  task automatic run_accept(input logic [6:0] srcs, input int exp_v, input string tag);
    bit v;
    for (int s = 0; s < 7; s++) if (srcs[s]) wr(loc_addr(s), loc_bit(s) + 1, 1'b0);
    @(negedge clk); evt_i = srcs;
    @(negedge clk); evt_i = '0;
    wr('h000, 0, 1'b1);
    @(negedge clk); instr_boundary = 1'b1;
    @(negedge clk); instr_boundary = 1'b0;
    check(seq_busy && !ctx_save && !vec_jump, {tag, " R7 cycle1"},
          {seq_busy, ctx_save, vec_jump}, 3'b100);
    @(negedge clk);
    rd_bit('h000, 0, v);
    check(ctx_save && !vec_jump && !v, {tag, " R7 cycle2 save, enable low"},
          {ctx_save, vec_jump, v}, 3'b100);
    @(negedge clk);
    check(ctx_save && vec_jump, {tag, " R7 cycle3 jump"}, {ctx_save, vec_jump}, 2'b11);
    check(vec_addr == 12'(exp_v), {tag, " R6 vector"}, vec_addr, exp_v);
    @(negedge clk);
    check(!seq_busy && vec_addr == 12'h0, {tag, " R7 done"}, {seq_busy, vec_addr}, 0);
    for (int s = 0; s < 7; s++) if (srcs[s]) begin
      read_flag(s, v);
      check(v == 1'b1, {tag, " R8 flag kept"}, v, 1);
    end
    for (int s = 0; s < 7; s++) if (srcs[s]) begin
      wr(loc_addr(s), loc_bit(s), 1'b0);
      wr(loc_addr(s), loc_bit(s) + 1, 1'b1);
    end
  endtask

  task automatic t_vectors;
    for (int s = 0; s < 7; s++) run_accept(7'(1 << s), exp_vec(s), "single");
    run_accept(7'b0010010, 'h004, "ext over timer C");
    run_accept(7'b1101000, 'h008, "timer B over shared");
    run_accept(7'b1100000, 'h00C, "serial and A/D shared");
  endtask

  task automatic t_no_reentry;
    int busy_cnt = 0;
    wr(loc_addr(1), loc_bit(1) + 1, 1'b0);
    pulse(1);
    wr('h000, 0, 1'b1);
    @(negedge clk); instr_boundary = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (seq_busy) busy_cnt++;
    end
    check(busy_cnt == 3, "R9 single sequence with boundary held", busy_cnt, 3);
    wr('h000, 0, 1'b1);
    @(negedge clk);
    check(seq_busy == 1'b1, "R9 re-armed by software", seq_busy, 1);
    instr_boundary = 1'b0;
    repeat (4) @(negedge clk);
    wr(loc_addr(1), loc_bit(1), 1'b0);
    wr(loc_addr(1), loc_bit(1) + 1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flag_writes();
    t_collision();
    t_pending();
    t_vectors();
    t_no_reentry();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule